// File: doc/BRIEF.md
# Pipelined Packed Multiply-Add Unit

This block is a fixed-latency arithmetic pipeline. Each operand is a packed vector of signed 16-bit lanes. The block multiplies every lane of operand A by the lane in the same position of operand B. It then adds the two products of each neighbouring lane pair and returns the sums as packed 32-bit words.

A mode bit travels with each operation. With the bit clear, the operation is narrow: four lanes from the low 64 bits produce two sums. With the bit set, the operation is wide: eight lanes produce four sums. The adds wrap in 32 bits and never saturate. No flags or exceptions come out of the block.

The input side uses a valid/ready handshake. An operation is taken on a rising clock edge when `in_valid` and `in_ready` are both high. A narrow operation can be taken on every cycle. After a wide operation is taken, `in_ready` drops for exactly one cycle, so wide operations issue at half the narrow rate. A source that sees `in_ready` low must keep its request pending, because a request offered during that cycle is not taken.

The output side carries no back-pressure. A result is presented for one cycle, with `out_valid` high, exactly `LATENCY` cycles after it was accepted. Results leave in the order they were accepted. The downstream logic must capture each result in the cycle it appears.

Top module: `pmadd_unit`

## Requirements
- R1: Result word k (bits 32k+31:32k) equals A[32k+15:32k]*B[32k+15:32k] + A[32k+31:32k+16]*B[32k+31:32k+16]. Each lane is a signed two's-complement 16-bit value, and each product is a signed 32-bit value.
- R2: With `in_wide`=1, all four result words k=0..3 are computed from all 128 operand bits.
- R3: With `in_wide`=0, only result words 0 and 1 are computed. Result bits 127:64 are zero, and operand bits 127:64 have no effect on the result.
- R4: A group whose four input lanes are all 0x8000 yields 0x80000000. The sum wraps and is not saturated.
- R5: An operation accepted in cycle c appears with `out_valid` high in cycle c+LATENCY (default 8). Each accepted operation gives exactly one valid cycle, and results keep their acceptance order.
- R6: After a narrow operation is accepted, `in_ready` is high in the next cycle, so narrow operations can issue every cycle.
- R7: After a wide operation is accepted, `in_ready` is low for exactly the next cycle and high in the cycle after that.
- R8: While `rst_n` is low and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R9: `in_valid` offered while `in_ready` is low is not accepted and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_wide | input | 1 | 1 selects the 128-bit operation, 0 selects the 64-bit operation |
| in_a | input | 128 | Packed signed 16-bit lanes of operand A |
| in_b | input | 128 | Packed signed 16-bit lanes of operand B |
| out_valid | output | 1 | `out_sum` holds a result this cycle |
| out_sum | output | 128 | Packed 32-bit sums |

## Verification
Some rules are checked by assertions on every cycle. These are the one-cycle ready gap after a wide issue and the unbroken ready after a narrow issue. They also cover the wrap to 0x80000000 inside each lane group and the zero upper half of every narrow result. Other behaviour can only be shown by the bench scenarios, which compare against a queue-based reference model. These are the arithmetic of random operands, the exact latency and ordering, and that upper operand bits have no effect in narrow mode. The same scenarios also show that requests offered during the ready gap are dropped.

// File: rtl/pmadd_pkg.sv
package pmadd_pkg;
  localparam int LANE_W  = 16;
  localparam int SUM_W   = 2 * LANE_W;
  localparam int GROUPS  = 4;
  localparam int DATA_W  = GROUPS * SUM_W;
  localparam int NARROW_GROUPS = GROUPS / 2;

  typedef logic signed [LANE_W-1:0] lane_t;
  typedef logic signed [SUM_W-1:0]  prod_t;
endpackage

// File: rtl/pmadd_pipe.sv
module pmadd_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/pmadd_group.sv
module pmadd_group
  import pmadd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] a,
  input  logic [SUM_W-1:0] b,
  output logic [SUM_W-1:0] sum
);
  prod_t lo_q, hi_q;
  logic [SUM_W-1:0] sum_q;

  // stage 1: two signed 16x16 products
  always_ff @(posedge clk) begin
    lo_q <= prod_t'(lane_t'(a[LANE_W-1:0]))      * prod_t'(lane_t'(b[LANE_W-1:0]));
    hi_q <= prod_t'(lane_t'(a[SUM_W-1:LANE_W]))  * prod_t'(lane_t'(b[SUM_W-1:LANE_W]));
  end

  // stage 2: wrapping 32-bit add
  always_ff @(posedge clk) begin
    sum_q <= lo_q + hi_q;
  end

  assign sum = sum_q;

  // R4: all four lanes at the most negative value wrap to 0x80000000
  p_corner_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a == 32'h8000_8000 && b == 32'h8000_8000) |-> ##2 (sum == 32'h8000_0000));
endmodule

// File: rtl/pmadd_issue.sv
module pmadd_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_wide,
  output logic in_ready,
  output logic accept
);
  logic gap_q;

  assign in_ready = !gap_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= accept && in_wide;
  end

  // R7: a wide issue closes the input for exactly one cycle
  p_wide_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_wide) |=> !in_ready);
  p_gap_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R6: a narrow issue never stalls the next one
  p_narrow_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_wide) |=> in_ready);
endmodule

// File: rtl/pmadd_unit.sv
module pmadd_unit
  import pmadd_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sum
);
  localparam int ARITH_STAGES = 2;
  localparam int TAIL_DEPTH   = LATENCY - ARITH_STAGES;
  localparam int HALF_W       = NARROW_GROUPS * SUM_W;

  initial begin
    if (LATENCY < ARITH_STAGES + 1) $error("LATENCY must be at least 3");
  end

  logic accept;
  logic [DATA_W-1:0] a_eff, b_eff, grp_sum;
  logic [1:0] ctl_out;
  logic out_wide;

  pmadd_issue u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_wide  (in_wide),
    .in_ready (in_ready),
    .accept   (accept)
  );

  // narrow mode: the upper lanes are forced to zero, so their sums are zero
  assign a_eff = in_wide ? in_a : {{HALF_W{1'b0}}, in_a[HALF_W-1:0]};
  assign b_eff = in_wide ? in_b : {{HALF_W{1'b0}}, in_b[HALF_W-1:0]};

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pmadd_group u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (a_eff[g*SUM_W +: SUM_W]),
      .b     (b_eff[g*SUM_W +: SUM_W]),
      .sum   (grp_sum[g*SUM_W +: SUM_W])
    );
  end

  pmadd_pipe #(.W(2), .DEPTH(LATENCY)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({accept, in_wide}),
    .q     (ctl_out)
  );

  pmadd_pipe #(.W(DATA_W), .DEPTH(TAIL_DEPTH)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (grp_sum),
    .q     (out_sum)
  );

  assign out_valid = ctl_out[1];
  assign out_wide  = ctl_out[0];

  // R3: narrow results never carry anything in the upper half
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> (out_sum[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/pmadd_unit_test.sv
module pmadd_unit_test;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_wide = 1'b0;
  logic [127:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [127:0] out_sum;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic exp_gap = 1'b0;
  int due_q[$];
  logic [127:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pmadd_unit #(.LATENCY(L)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  function automatic logic [127:0] ref_model(logic [127:0] a, logic [127:0] b, logic w);
    logic [127:0] r = '0;
    for (int g = 0; g < (w ? 4 : 2); g++) begin
      longint p0 = longint'($signed(a[32*g +: 16])) * longint'($signed(b[32*g +: 16]));
      longint p1 = longint'($signed(a[32*g+16 +: 16])) * longint'($signed(b[32*g+16 +: 16]));
      longint s = p0 + p1;
      r[32*g +: 32] = s[31:0];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one cycle: compare outputs with the model, then drive new inputs
  task automatic cycle(bit v, bit w, logic [127:0] a, logic [127:0] b, string tag);
    bit exp_valid;
    @(negedge clk);
    cyc++;
    exp_valid = (due_q.size() > 0) && (due_q[0] == cyc);
    if (!rst_n) begin
      check(out_valid == 1'b0, "R8 out_valid in reset", 128'(out_valid), 128'(0));
      check(in_ready == 1'b1, "R8 in_ready in reset", 128'(in_ready), 128'(1));
    end else begin
      check(out_valid == exp_valid, "R5 out_valid timing", 128'(out_valid), 128'(exp_valid));
      check(in_ready == !exp_gap, exp_gap ? "R7 ready gap" : "R6 ready high",
            128'(in_ready), 128'(!exp_gap));
      if (exp_valid) begin
        check(out_sum == exp_q[0], tag_q[0], out_sum, exp_q[0]);
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    in_valid = v; in_wide = w; in_a = a; in_b = b;
    if (rst_n) begin
      // R9: an offer during the gap is not queued
      if (v && !exp_gap) begin
        due_q.push_back(cyc + L);
        exp_q.push_back(ref_model(a, b, w));
        tag_q.push_back(tag);
      end
      exp_gap = v && !exp_gap && w;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) cycle(0, 0, '0, '0, "");
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) cycle(0, 0, '0, '0, "");

    // R1: simple known values, narrow
    cycle(1, 0, 128'h0000_0000_0000_0000_0003_0002_FFFF_0004,
                128'h0000_0000_0000_0000_0005_0007_0002_0006, "R1 known narrow");
    // R3: garbage in upper operand half must not leak
    cycle(1, 0, {64'hDEAD_BEEF_1234_5678, 64'h7FFF_8000_0001_FFFF},
                {64'hCAFE_F00D_8765_4321, 64'h7FFF_7FFF_8000_0002}, "R3 narrow ignores upper");
    // R4: corner wrap in narrow and wide mode
    cycle(1, 0, {64'h0, {4{16'h8000}}}, {64'h0, {4{16'h8000}}}, "R4 corner narrow");
    cycle(1, 1, {8{16'h8000}}, {8{16'h8000}}, "R4 corner wide");
    // R9: offered during the gap, dropped
    cycle(1, 1, rnd128(), rnd128(), "R9 dropped");
    // R2: wide known values
    cycle(1, 1, {16'd1, 16'd2, 16'd3, 16'd4, 16'hFFFF, 16'hFFFE, 16'h7FFF, 16'h7FFF},
                {16'd5, 16'd6, 16'd7, 16'd8, 16'h0003, 16'h0004, 16'h7FFF, 16'h7FFF}, "R2 known wide");
    cycle(1, 0, rnd128(), rnd128(), "R9 dropped narrow");
    // R6: narrow back-to-back stream
    for (int i = 0; i < 20; i++) cycle(1, 0, rnd128(), rnd128(), "R6 narrow stream");
    // R7: wide held valid, issues every second cycle
    for (int i = 0; i < 20; i++) cycle(1, 1, rnd128(), rnd128(), "R7 wide stream");
    for (int i = 0; i < L + 2; i++) cycle(0, 0, '0, '0, "");
    // R1/R2/R5: random mix of modes and valid
    for (int i = 0; i < 400; i++)
      cycle(($urandom % 4) != 0, $urandom % 2, rnd128(), rnd128(), "R1 random mix");
    for (int i = 0; i < L + 2; i++) cycle(0, 0, '0, '0, "");
    check(due_q.size() == 0, "R5 all results delivered", 128'(due_q.size()), 128'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule